// File: doc/BRIEF.md
# Processor Startup IPI Sequencer

This block wakes a sleeping processor by issuing the standard wake-up series of inter-processor interrupt messages. It does this as a bus master on a 32-bit command register interface. A one-cycle `start` pulse supplies three things: an 8-bit target identifier, a broadcast flag meaning "every processor except the sender", and the physical address of the start-up routine.

The block first checks the routine address. It then sends an INIT message, waits a fixed time, sends a START-UP message, waits a longer fixed time, and sends the same START-UP message again. Each message takes two register writes. The high command word is written first and the low command word second, and writing the low word launches the message. After that write the block keeps reading the low word until its delivery-status bit reads clear, and only then goes on to the next step.

A single-cycle `done` pulse marks the end of a good sequence. A single-cycle `err` pulse marks a rejected address, and in that case no bus traffic happens. Delays are given in microseconds and turned into clock cycles through the `CYCLES_PER_US` parameter.

Top module: `ipi_wake_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `req_valid` are all low.
- R2: Each message is a write to offset 0x310 (high word) and then a write to offset 0x300 (low word). For a directed message the high word is the target ID in bits [31:24] with all other bits zero.
- R3: After the low-word write, the block issues reads of offset 0x300 only. It keeps reading until a read is accepted with bit 12 clear, and it issues exactly one read per accepted-busy response plus the final clear one.
- R4: The messages go out in the order INIT, START-UP, START-UP, six writes in all. Every low word has bit 14 set. Bits [10:8] hold 3'b101 for INIT and 3'b110 for START-UP.
- R5: In START-UP low words, bits [7:0] equal the routine address bits [19:12]. In the INIT low word, bits [7:0] are zero.
- R6: In broadcast mode the high word is zero and low-word bits [19:18] are 2'b11. In directed mode those bits are 2'b00.
- R7: The next message's request rises exactly D+4 clock edges after the edge that accepted the final clear poll. D is `INIT_WAIT_US*CYCLES_PER_US` after INIT and `SIPI_WAIT_US*CYCLES_PER_US` after the first START-UP.
- R8: An address of 0x100000 or above, or one that is not 4 KB aligned, gives a one-cycle `err` on the edge that sees `start`. No bus request follows, and no `done`.
- R9: `done` is a one-cycle pulse, visible on the second edge after the final poll of the last message is accepted. `busy` is high from the edge after `start` until `done`.
- R10: A `start` pulse while `busy` is high is ignored. It changes no written value and raises no `err`.
- R11: While `req_valid` is high and `req_ready` is low, the request's write flag, offset and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the wake-up sequence |
| target_id | input | 8 | Identifier of the processor to wake |
| broadcast | input | 1 | Address every processor except the sender |
| routine_addr | input | 32 | Physical address of the start-up routine |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a good sequence |
| err | output | 1 | One-cycle pulse when the address is rejected |
| req_valid | output | 1 | Bus request present |
| req_write | output | 1 | 1 = write, 0 = read |
| req_offset | output | 12 | Register byte offset |
| req_wdata | output | 32 | Write data |
| req_ready | input | 1 | Bus accepts the request on this edge |
| rd_data | input | 32 | Read data, valid in the accepting cycle |

## Verification
The bench sweeps several target IDs, both addressing modes, routine addresses at the bottom, middle and top of the legal range, zero to three busy poll responses, and three bus back-pressure patterns. For every run it checks each written word and offset. A design that read the vector from the wrong address bits, mixed up the shorthand, or left the ID in the high word during broadcast would write a wrong value. A design that moved on before the status cleared would show too few reads, and one with a wrong delay count would miss the exact gap. Rejected addresses (just over the limit, misaligned, far out of range) must pulse `err` with no bus traffic. A second `start` in mid-sequence must leave the written values unchanged, so a design that relatched it would be caught.

// File: rtl/ipi_seq_pkg.sv
package ipi_seq_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 12;
  localparam int VEC_W  = 8;

  localparam logic [OFF_W-1:0] OFF_CMD_LO = 12'h300;
  localparam logic [OFF_W-1:0] OFF_CMD_HI = 12'h310;

  localparam int LVL_BIT  = 14;
  localparam int STAT_BIT = 12;
  localparam int ID_LSB   = 24;

  typedef enum logic [2:0] {
    DM_INIT    = 3'b101,
    DM_STARTUP = 3'b110
  } dmode_e;

  localparam logic [1:0] SH_NONE         = 2'b00;
  localparam logic [1:0] SH_ALL_BUT_SELF = 2'b11;

  function automatic logic [DATA_W-1:0] make_lo(input logic [VEC_W-1:0] vec,
                                                input dmode_e dm,
                                                input logic bc);
    logic [DATA_W-1:0] w;
    w          = '0;
    w[7:0]     = vec;
    w[10:8]    = dm;
    w[LVL_BIT] = 1'b1;
    w[19:18]   = bc ? SH_ALL_BUT_SELF : SH_NONE;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] make_hi(input logic [VEC_W-1:0] tid,
                                                input logic bc);
    logic [DATA_W-1:0] w;
    w = '0;
    if (!bc) w[ID_LSB +: VEC_W] = tid;
    return w;
  endfunction
endpackage

// File: rtl/ipi_addr_check.sv
module ipi_addr_check #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 12,
  parameter int LIMIT_BITS = 20,
  parameter int VEC_W      = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ok,
  output logic [VEC_W-1:0]  vector
);
  logic aligned;
  logic in_range;

  assign aligned = (addr[ALIGN_BITS-1:0] == '0);

  generate
    if (LIMIT_BITS < ADDR_W) begin : g_limit
      assign in_range = (addr[ADDR_W-1:LIMIT_BITS] == '0);
    end else begin : g_nolimit
      assign in_range = 1'b1;
    end
  endgenerate

  assign ok     = aligned && in_range;
  assign vector = addr[ALIGN_BITS +: VEC_W];
endmodule

// File: rtl/ipi_delay_timer.sv
module ipi_delay_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      run    <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        cnt <= count - 1'b1;
        run <= 1'b1;
      end else if (run) begin
        if (cnt == '0) begin
          expire <= 1'b1;
          run    <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assert_expire_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);
  assert_expire_needs_run_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(expire) |-> $past(run));
endmodule

// File: rtl/ipi_cmd_master.sv
module ipi_cmd_master
  import ipi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DATA_W-1:0] hi_word,
  input  logic [DATA_W-1:0] lo_word,
  output logic              msg_done,
  output logic              req_valid,
  output logic              req_write,
  output logic [OFF_W-1:0]  req_offset,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              req_ready,
  input  logic [DATA_W-1:0] rd_data
);
  typedef enum logic [1:0] {M_IDLE, M_HI, M_LO, M_POLL} mst_e;
  mst_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= M_IDLE;
      req_valid  <= 1'b0;
      req_write  <= 1'b0;
      req_offset <= '0;
      req_wdata  <= '0;
      msg_done   <= 1'b0;
    end else begin
      msg_done <= 1'b0;
      case (st)
        M_IDLE: if (go) begin
          req_valid  <= 1'b1;
          req_write  <= 1'b1;
          req_offset <= OFF_CMD_HI;
          req_wdata  <= hi_word;
          st         <= M_HI;
        end
        M_HI: if (req_ready) begin
          req_offset <= OFF_CMD_LO;
          req_wdata  <= lo_word;
          st         <= M_LO;
        end
        M_LO: if (req_ready) begin
          req_write <= 1'b0;
          req_wdata <= '0;
          st        <= M_POLL;
        end
        M_POLL: if (req_ready && !rd_data[STAT_BIT]) begin
          req_valid <= 1'b0;
          msg_done  <= 1'b1;
          st        <= M_IDLE;
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_write) &&
                                   $stable(req_offset) && $stable(req_wdata)));
  assert_poll_offset_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |-> (req_offset == OFF_CMD_LO));
  assert_done_after_clear_R3: assert property (@(posedge clk) disable iff (rst)
    msg_done |-> $past(req_valid && req_ready && !req_write && !rd_data[STAT_BIT]));
  assert_go_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    go |-> (st == M_IDLE));
endmodule

// File: rtl/ipi_wake_seq.sv
module ipi_wake_seq
  import ipi_seq_pkg::*;
#(
  parameter int CYCLES_PER_US = 125,
  parameter int INIT_WAIT_US  = 10,
  parameter int SIPI_WAIT_US  = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        target_id,
  input  logic              broadcast,
  input  logic [31:0]       routine_addr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              req_valid,
  output logic              req_write,
  output logic [11:0]       req_offset,
  output logic [31:0]       req_wdata,
  input  logic              req_ready,
  input  logic [31:0]       rd_data
);
  localparam int INIT_CYC = INIT_WAIT_US * CYCLES_PER_US;
  localparam int SIPI_CYC = SIPI_WAIT_US * CYCLES_PER_US;
  localparam int MAX_CYC  = (INIT_CYC > SIPI_CYC) ? INIT_CYC : SIPI_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {T_IDLE, T_INIT, T_WAIT1, T_SIPI1, T_WAIT2, T_SIPI2} top_e;
  top_e st;

  logic             addr_ok;
  logic [VEC_W-1:0] addr_vec;
  logic [VEC_W-1:0] tid_q, vec_q;
  logic             bc_q, sipi_q;
  logic             go, msg_done, tm_load, tm_expire;
  logic [CNT_W-1:0] tm_count;
  logic [DATA_W-1:0] hi_word, lo_word;

  ipi_addr_check #(
    .ADDR_W(32), .ALIGN_BITS(12), .LIMIT_BITS(20), .VEC_W(VEC_W)
  ) u_chk (
    .addr(routine_addr), .ok(addr_ok), .vector(addr_vec)
  );

  assign hi_word = make_hi(tid_q, bc_q);
  assign lo_word = make_lo(sipi_q ? vec_q : '0, sipi_q ? DM_STARTUP : DM_INIT, bc_q);
  assign busy    = (st != T_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= T_IDLE;
      tid_q    <= '0;
      vec_q    <= '0;
      bc_q     <= 1'b0;
      sipi_q   <= 1'b0;
      go       <= 1'b0;
      tm_load  <= 1'b0;
      tm_count <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      go      <= 1'b0;
      tm_load <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      case (st)
        T_IDLE: if (start) begin
          if (!addr_ok) begin
            err <= 1'b1;
          end else begin
            tid_q  <= target_id;
            vec_q  <= addr_vec;
            bc_q   <= broadcast;
            sipi_q <= 1'b0;
            go     <= 1'b1;
            st     <= T_INIT;
          end
        end
        T_INIT: if (msg_done) begin
          tm_load  <= 1'b1;
          tm_count <= CNT_W'(INIT_CYC);
          st       <= T_WAIT1;
        end
        T_WAIT1: if (tm_expire) begin
          sipi_q <= 1'b1;
          go     <= 1'b1;
          st     <= T_SIPI1;
        end
        T_SIPI1: if (msg_done) begin
          tm_load  <= 1'b1;
          tm_count <= CNT_W'(SIPI_CYC);
          st       <= T_WAIT2;
        end
        T_WAIT2: if (tm_expire) begin
          go <= 1'b1;
          st <= T_SIPI2;
        end
        T_SIPI2: if (msg_done) begin
          done <= 1'b1;
          st   <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  ipi_delay_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tm_load), .count(tm_count), .expire(tm_expire)
  );

  ipi_cmd_master u_mst (
    .clk(clk), .rst(rst), .go(go), .hi_word(hi_word), .lo_word(lo_word),
    .msg_done(msg_done), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data)
  );

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !req_valid));
  assert_err_no_req_R8: assert property (@(posedge clk) disable iff (rst)
    err |=> !req_valid);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  assert_busy_start_no_err_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !err);
endmodule

// File: tb/ipi_wake_seq_bench.sv
module ipi_wake_seq_bench;
  localparam int CYC_US = 2;
  localparam int INIT_N = 10 * CYC_US;
  localparam int SIPI_N = 200 * CYC_US;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] target_id = '0;
  logic broadcast = 1'b0;
  logic [31:0] routine_addr = '0;
  logic busy, done, err, req_valid, req_write;
  logic [11:0] req_offset;
  logic [31:0] req_wdata;
  logic req_ready = 1'b0;
  logic [31:0] rd_data = '0;

  always #4 clk = ~clk;

  ipi_wake_seq #(.CYCLES_PER_US(CYC_US), .INIT_WAIT_US(10), .SIPI_WAIT_US(200)) u_ipi_wake_seq (
    .clk(clk), .rst(rst), .start(start), .target_id(target_id), .broadcast(broadcast),
    .routine_addr(routine_addr), .busy(busy), .done(done), .err(err),
    .req_valid(req_valid), .req_write(req_write), .req_offset(req_offset),
    .req_wdata(req_wdata), .req_ready(req_ready), .rd_data(rd_data)
  );

  int checks = 0, errors = 0;
  int cyc = 0, ncnt = 0;
  int wr_n = 0, rd_tot = 0, pend = 0, poll_n = 0, rdy_mode = 0;
  int last_ack = 0, done_cnt = 0, done_gap = 0, err_cnt = 0, bad_rd = 0;
  int rd_per[4];
  int gap[4];
  logic [11:0] wr_off[8];
  logic [31:0] wr_dat[8];
  logic prev_valid = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus slave: drive at negedge
  always @(negedge clk) begin
    ncnt++;
    req_ready = (rdy_mode == 0) || ((ncnt % (rdy_mode + 1)) == 0);
    rd_data   = (pend != 0) ? 32'h0000_1000 : 32'h0;
  end

  // monitor: sample pre-edge values at posedge
  always @(posedge clk) begin
    cyc++;
    if (!rst) begin
      if (req_valid && !prev_valid && wr_n > 0 && wr_n < 8) gap[wr_n/2] = cyc - last_ack;
      if (req_valid && req_ready) begin
        if (req_write) begin
          if (wr_n < 8) begin
            wr_off[wr_n] = req_offset;
            wr_dat[wr_n] = req_wdata;
          end
          if (req_offset == 12'h300) pend = poll_n;
          wr_n++;
        end else begin
          rd_tot++;
          if (req_offset != 12'h300) bad_rd++;
          if (wr_n >= 1 && wr_n <= 8) rd_per[(wr_n-1)/2]++;
          if (pend == 0) last_ack = cyc;
          else pend--;
        end
      end
      if (done) begin
        done_cnt++;
        done_gap = cyc - last_ack;
      end
      if (err) err_cnt++;
      prev_valid = req_valid;
    end
  end

  task automatic clear_log();
    wr_n = 0; rd_tot = 0; done_cnt = 0; err_cnt = 0; bad_rd = 0; pend = 0;
    for (int i = 0; i < 4; i++) begin rd_per[i] = 0; gap[i] = 0; end
  endtask

  function automatic logic [31:0] exp_lo(input logic [2:0] dm, input logic [7:0] vec, input logic bc);
    return (32'd1 << 14) | (32'(dm) << 8) | (bc ? (32'd3 << 18) : 32'd0) | 32'(vec);
  endfunction

  task automatic pulse_start(input logic [7:0] tid, input logic bc, input logic [31:0] addr);
    @(negedge clk);
    start = 1'b1; target_id = tid; broadcast = bc; routine_addr = addr;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    chk("R9 sequence completes", {31'h0, busy}, 32'h0);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_seq(input logic [7:0] tid, input logic bc, input logic [31:0] addr,
                         input int polls, input int mode, input bit interrupt);
    logic [31:0] hi;
    clear_log();
    poll_n = polls; rdy_mode = mode;
    pulse_start(tid, bc, addr);
    chk("R9 busy after start", {31'h0, busy}, 32'h1);
    if (interrupt) begin
      repeat (30) @(negedge clk);
      pulse_start(~tid, ~bc, addr ^ 32'h0001_0000);
      chk("R10 late start no err", err_cnt, 0);
    end
    wait_idle();
    hi = bc ? 32'h0 : {tid, 24'h0};
    chk("R4 write count", wr_n, 6);
    for (int m = 0; m < 3; m++) begin
      chk("R2 high offset", {20'h0, wr_off[2*m]}, 32'h310);
      chk("R2/R6 high word", wr_dat[2*m], hi);
      chk("R2 low offset", {20'h0, wr_off[2*m+1]}, 32'h300);
      chk("R4/R5/R6 low word", wr_dat[2*m+1],
          exp_lo(m == 0 ? 3'b101 : 3'b110, m == 0 ? 8'h00 : addr[19:12], bc));
      chk("R3 polls per message", rd_per[m], polls + 1);
    end
    chk("R3 poll offset", bad_rd, 0);
    chk("R7 gap after INIT", gap[1], INIT_N + 5);
    chk("R7 gap after START-UP", gap[2], SIPI_N + 5);
    chk("R9 one done", done_cnt, 1);
    chk("R9 done timing", done_gap, 2);
    chk("R10 no err", err_cnt, 0);
  endtask

  task automatic run_bad(input logic [31:0] addr);
    clear_log();
    @(negedge clk);
    start = 1'b1; target_id = 8'h33; broadcast = 1'b0; routine_addr = addr;
    @(negedge clk);
    start = 1'b0;
    chk("R8 err pulse", {31'h0, err}, 32'h1);
    chk("R8 not busy", {31'h0, busy}, 32'h0);
    @(negedge clk);
    chk("R8 err one cycle", {31'h0, err}, 32'h0);
    repeat (30) @(negedge clk);
    chk("R8 no writes", wr_n, 0);
    chk("R8 no reads", rd_tot, 0);
    chk("R8 no done", done_cnt, 0);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  tids [3];
    logic [31:0] addrs [3];
    int k = 0;
    tids[0] = 8'h00; tids[1] = 8'h5A; tids[2] = 8'hFF;
    addrs[0] = 32'h0000_0000; addrs[1] = 32'h0009_F000; addrs[2] = 32'h000F_F000;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy reset", {31'h0, busy}, 32'h0);
    chk("R1 done reset", {31'h0, done}, 32'h0);
    chk("R1 err reset", {31'h0, err}, 32'h0);
    chk("R1 req_valid reset", {31'h0, req_valid}, 32'h0);

    for (int t = 0; t < 3; t++)
      for (int b = 0; b < 2; b++)
        for (int a = 0; a < 3; a++) begin
          run_seq(tids[t], b[0], addrs[a], k % 4, k % 3, 1'b0);
          k++;
        end

    run_seq(8'h21, 1'b0, 32'h0004_2000, 1, 2, 1'b1);
    run_seq(8'h7E, 1'b1, 32'h0008_8000, 2, 1, 1'b1);

    run_bad(32'h0010_0000);
    run_bad(32'h0000_0800);
    run_bad(32'h0000_1004);
    run_bad(32'hFFFF_F000);
    run_bad(32'h000F_FFFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule